// File: doc/BRIEF.md
# Output Driver Impedance Update Sequencer

This block holds the drive-strength code that sets the impedance of a memory's data output drivers. A separate measurement circuit produces a digital target code; this sequencer moves the code that actually reaches the drivers toward that target. It moves the code one step per cycle, and only in cycles where the data pins are tristated. As a result, the drive strength never changes while a read is putting data on the bus.

The drivers are tristated in three cases: a write cycle, a deselect cycle, or the output enable held inactive at the clock edge. Each such clock edge is an update opportunity. After reset the code is zero, which means minimum impedance and strongest drive. A reference pin that is open or tied to the supply forces the target to the all-ones code, which is maximum impedance. With the default 10-bit code, a full climb from minimum to maximum takes 1023 update opportunities.

Top module: `zq_update_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `drive_code` becomes 0 (minimum impedance) and the held target becomes 0.
- R2: `drive_code` does not change at a clock edge where the outputs are driving (`cs`=1, `we`=0, `oe_n`=0). `drv_hiz` is 0 exactly in that case.
- R3: A write edge (`cs`=1, `we`=1) is an update opportunity, and `drv_hiz` is 1.
- R4: A deselect edge (`cs`=0) is an update opportunity, and `drv_hiz` is 1.
- R5: A read edge with `oe_n`=1 is an update opportunity, and `drv_hiz` is 1.
- R6: At an update opportunity where `drive_code` is below the held target, `drive_code` rises by exactly 1.
- R7: At an update opportunity where `drive_code` is above the held target, `drive_code` falls by exactly 1.
- R8: At an update opportunity where `drive_code` equals the held target, `drive_code` holds.
- R9: When `ref_open`=1 at an edge, the held target becomes all ones (maximum impedance), whatever `tgt_code` is.
- R10: `tgt_code` is captured into the held target at every edge. The step taken at an edge uses the target held before that edge, so a new target steers the code one edge later.
- R11: Starting from reset with a constant update opportunity and `ref_open`=1, `drive_code` reaches 1023 only after more than 1000 edges, and it reaches 1023 within 1030 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| tgt_code | input | 10 | Target impedance code from the measurement circuit |
| ref_open | input | 1 | Reference pin open or tied high; forces the maximum-impedance target |
| cs | input | 1 | Chip select, sampled at the clock edge |
| we | input | 1 | Write enable, sampled at the clock edge |
| oe_n | input | 1 | Output enable, active low, sampled at the clock edge |
| drive_code | output | 10 | Active drive-strength code applied to the output stage |
| drv_hiz | output | 1 | High when the data drivers are tristated in the current cycle |

## Verification
The assertions check the following on every cycle: the code is frozen on driving edges, it moves by at most one step and always toward the held target, it holds once it matches, reset returns it to zero, and an open reference loads the all-ones target. Some behaviours depend on a whole sequence of cycles, and only the bench's scenarios can show them. These are the one-edge lag between a new target and the first step it causes, the length of the full minimum-to-maximum climb, and the fact that each kind of tristate cycle (write, deselect, disabled output) actually produces progress.

// File: rtl/zq_seq_pkg.sv
package zq_seq_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    typedef struct packed {
        logic read_drive;
        logic write_hiz;
        logic desel_hiz;
        logic oe_hiz;
    } bus_state_t;

    function automatic step_e pick_step(input logic below, input logic above);
        if (below)      return STEP_UP;
        else if (above) return STEP_DOWN;
        else            return STEP_HOLD;
    endfunction

    function automatic bus_state_t classify(input logic cs, input logic we, input logic oe_n);
        bus_state_t s;
        s.desel_hiz  = ~cs;
        s.write_hiz  = cs & we;
        s.oe_hiz     = cs & ~we & oe_n;
        s.read_drive = cs & ~we & ~oe_n;
        return s;
    endfunction

endpackage

// File: rtl/zq_window.sv
module zq_window
    import zq_seq_pkg::*;
(
    input  logic cs,
    input  logic we,
    input  logic oe_n,
    output logic win
);
    bus_state_t st;

    always_comb begin
        st  = classify(cs, we, oe_n);
        win = st.write_hiz | st.desel_hiz | st.oe_hiz;
    end
endmodule

// File: rtl/zq_target.sv
module zq_target #(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] tgt_code,
    input  logic              ref_open,
    output logic [CODE_W-1:0] tgt_q
);
    localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)           tgt_q <= '0;
        else if (ref_open) tgt_q <= MAX_CODE;
        else               tgt_q <= tgt_code;
    end
endmodule

// File: rtl/zq_stepper.sv
module zq_stepper
    import zq_seq_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win,
    input  logic [CODE_W-1:0] tgt_q,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

    step_e             dir;
    logic [CODE_W-1:0] code_nxt;

    always_comb begin
        dir      = pick_step(code < tgt_q, code > tgt_q);
        code_nxt = code;
        if (win) begin
            case (dir)
                STEP_UP:   code_nxt = code + ONE;
                STEP_DOWN: code_nxt = code - ONE;
                default:   code_nxt = code;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) code <= '0;
        else     code <= code_nxt;
    end
endmodule

// File: rtl/zq_update_seq.sv
module zq_update_seq #(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] tgt_code,
    input  logic              ref_open,
    input  logic              cs,
    input  logic              we,
    input  logic              oe_n,
    output logic [CODE_W-1:0] drive_code,
    output logic              drv_hiz
);
    logic [CODE_W-1:0] tgt_q;

    zq_window u_window (
        .cs   (cs),
        .we   (we),
        .oe_n (oe_n),
        .win  (drv_hiz)
    );

    zq_target #(.CODE_W(CODE_W)) u_target (
        .clk      (clk),
        .rst      (rst),
        .tgt_code (tgt_code),
        .ref_open (ref_open),
        .tgt_q    (tgt_q)
    );

    zq_stepper #(.CODE_W(CODE_W)) u_stepper (
        .clk   (clk),
        .rst   (rst),
        .win   (drv_hiz),
        .tgt_q (tgt_q),
        .code  (drive_code)
    );
endmodule

// File: rtl/zq_update_seq_chk.sv
module zq_update_seq_chk #(
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              ref_open,
    input logic              cs,
    input logic              we,
    input logic              oe_n,
    input logic [CODE_W-1:0] drive_code,
    input logic              drv_hiz,
    input logic [CODE_W-1:0] tgt_q
);
    localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] ONE      = CODE_W'(1);

    p_reset_min_r1: assert property (@(posedge clk)
        rst |=> (drive_code == '0 && tgt_q == '0));

    p_frozen_drive_r2: assert property (@(posedge clk) disable iff (rst)
        (cs && !we && !oe_n) |=> $stable(drive_code));

    p_window_flag_r2: assert property (@(posedge clk)
        drv_hiz == !(cs && !we && !oe_n));

    p_step_up_r6: assert property (@(posedge clk) disable iff (rst)
        (drv_hiz && drive_code < tgt_q) |=> (drive_code == $past(drive_code) + ONE));

    p_step_down_r7: assert property (@(posedge clk) disable iff (rst)
        (drv_hiz && drive_code > tgt_q) |=> (drive_code == $past(drive_code) - ONE));

    p_hold_equal_r8: assert property (@(posedge clk) disable iff (rst)
        (drive_code == tgt_q) |=> $stable(drive_code));

    p_open_ref_r9: assert property (@(posedge clk) disable iff (rst)
        ref_open |=> (tgt_q == MAX_CODE));
endmodule

bind zq_update_seq zq_update_seq_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ref_open   (ref_open),
    .cs         (cs),
    .we         (we),
    .oe_n       (oe_n),
    .drive_code (drive_code),
    .drv_hiz    (drv_hiz),
    .tgt_q      (tgt_q)
);

// File: tb/test_zq_update_seq.sv
`timescale 1ns/1ps
module test_zq_update_seq;
    localparam int CW  = 10;
    localparam int MAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] tgt_code = '0;
    logic          ref_open = 1'b0;
    logic          cs = 1'b0;
    logic          we = 1'b0;
    logic          oe_n = 1'b0;
    logic [CW-1:0] drive_code;
    logic          drv_hiz;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    int m_code  = 0;
    int m_tgt   = 0;

    always #2 clk = ~clk;

    zq_update_seq #(.CODE_W(CW)) i_zq_update_seq (
        .clk(clk), .rst(rst), .tgt_code(tgt_code), .ref_open(ref_open),
        .cs(cs), .we(we), .oe_n(oe_n), .drive_code(drive_code), .drv_hiz(drv_hiz)
    );

    // behavioural reference: step on old target, then capture new target
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_code = 0;
            m_tgt  = 0;
        end else begin
            bit tri_now;
            tri_now = !(cs && !we && !oe_n);
            if (tri_now) begin
                if (m_code < m_tgt)      m_code = m_code + 1;
                else if (m_code > m_tgt) m_code = m_code - 1;
            end
            m_tgt = ref_open ? MAX : int'(tgt_code);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input string req, input logic c, input logic w, input logic o,
                       input int tgt, input logic ro, input int n);
        for (int i = 0; i < n; i++) begin
            cs = c; we = w; oe_n = o; tgt_code = CW'(tgt); ref_open = ro;
            @(negedge clk);
            check(req, int'(drive_code), m_code);
            check(req, int'(drv_hiz), int'(!(c && !w && !o)));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(drive_code), 0);
        rst = 1'b0;
        // R2: reads keep the code frozen although target differs
        run("R2", 1, 0, 0, 5, 0, 6);
        check("R2", int'(drive_code), 0);
        // R3: writes climb; R10: first edge still sees old target 5
        run("R3", 1, 1, 0, 5, 0, 3);
        check("R3", int'(drive_code), 3);
        run("R10", 1, 1, 0, 9, 0, 1);
        check("R10", int'(drive_code), 4);
        run("R4", 0, 0, 0, 9, 0, 3);
        check("R4", int'(drive_code), 7);
        run("R5", 1, 0, 1, 9, 0, 4);
        check("R8", int'(drive_code), 9);
        run("R8", 0, 0, 0, 9, 0, 5);
        check("R8", int'(drive_code), 9);
        // R7: lower target, steps down; interleave reads
        run("R7", 0, 0, 0, 2, 0, 3);
        check("R7", int'(drive_code), 7);
        run("R2", 1, 0, 0, 2, 0, 4);
        check("R2", int'(drive_code), 7);
        run("R7", 1, 1, 0, 2, 0, 6);
        check("R7", int'(drive_code), 2);
        // R9: open reference overrides a small target
        run("R9", 0, 0, 0, 1, 1, 4);
        check("R9", int'(drive_code), 5);
        // R1: mid-run reset
        rst = 1'b1;
        run("R1", 0, 0, 0, 1, 1, 2);
        check("R1", int'(drive_code), 0);
        rst = 1'b0;
        // R11: full sweep
        run("R11", 0, 0, 0, 0, 1, 1000);
        check("R11", int'(drive_code < CW'(MAX)), 1);
        run("R11", 0, 0, 0, 0, 1, 30);
        check("R11", int'(drive_code), MAX);
        run("R6", 1, 0, 1, 0, 1, 3);
        check("R6", int'(drive_code), MAX);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        wait (cycles > 50000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule